// File: doc/BRIEF.md
# Single-Slope Pulse-Width Modulator with Buffered Compare

This block produces a pulse-width modulated level from a 16-bit up-counter. The counter starts at zero, climbs by one on each enabled tick until it holds the current ceiling value, and then returns to zero on the next enabled tick. The output level is raised when the count meets the compare value and dropped when the count sits at the ceiling. A polarity input selects the plain or the inverted form of that level. Because the counter only counts up, one period is the ceiling plus one ticks.

The ceiling comes from one of four sources. Three of them are fixed 8-, 9- and 10-bit maximum values. The fourth is a writable period register. The compare value and the period register are both written into a holding buffer. Their working copies are refreshed only when the counter wraps to zero, so software can rewrite them at any time without a glitch or a missed match. A sticky flag records that the counter reached the ceiling, and it stays set until it is cleared.

The tick input is driven by an external divider. Registers are written through single-cycle write strobes.

Top module: `pwm_single_slope`

## Requirements
- R1: After a synchronous active-low reset, the counter, the output level, the overflow flag, and both the buffered and the working copies of the compare and period values are zero. With polarity 0, `pwm_out` reads 0.
- R2: The counter changes only in cycles where `tick` is 1. With `tick` at 0, neither the output level nor the flag-setting condition advances.
- R3: The ceiling is selected by `top_mode`: 0 gives 0x00FF, 1 gives 0x01FF, 2 gives 0x03FF, and 3 gives the working period value. On a tick while the count equals the ceiling, the count becomes 0. On any other tick, the count increases by one.
- R4: On a tick where the count equals the working compare value, the level becomes 1. On a tick where the count equals the ceiling, the level becomes 0. When both hold, the compare match wins. With `pwm_invert` = 0, `pwm_out` equals the level.
- R5: With `pwm_invert` = 1, `pwm_out` is the complement of the level, so it is cleared at the match and set at the ceiling.
- R6: A write on `cmp_we` updates only the compare buffer. The working compare value takes the buffer contents on a tick where the count equals the ceiling. A write in that same cycle takes effect at the following wrap.
- R7: A write on `per_we` updates only the period buffer. The working period value, which is the ceiling in mode 3, takes the buffer contents on the same wrap ticks described in R6.
- R8: The overflow flag is set on the tick after which the count equals the ceiling. This includes a ceiling of 0, where every tick sets the flag. Once set, the flag stays set until it is cleared.
- R9: `ovf_clr` clears the flag in the next cycle, unless the flag is being set in that same cycle, in which case the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Count enable, one cycle per step |
| top_mode | input | 2 | Ceiling source: 0/1/2 fixed 8/9/10-bit, 3 period register |
| pwm_invert | input | 1 | 1 selects the inverted output |
| cmp_we | input | 1 | Write strobe for the compare buffer |
| cmp_wdata | input | 16 | Compare value to buffer |
| per_we | input | 1 | Write strobe for the period buffer |
| per_wdata | input | 16 | Period value to buffer |
| ovf_clr | input | 1 | Clears the overflow flag |
| pwm_out | output | 1 | Modulated output |
| ovf_flag | output | 1 | Sticky flag, counter reached the ceiling |

## Verification
Two pairs of events can fall in the same cycle, and both are provoked deliberately. The first pair is a buffer write and the wrap that copies the buffer. The bench strobes `cmp_we` and `per_we` in exactly the cycle where the count sits at the ceiling. It then checks that the old buffered value governs the next period and the new value governs the one after. The second pair is a flag clear and a flag set. The bench pulses `ovf_clr` on the tick that brings the count to the ceiling, including a zero ceiling where every tick sets the flag, and judges the outcome against R9.

// File: rtl/pwm_pkg.sv
// Package: shared types and constants for the single-slope modulator.
// Assumes the counter width is at least 10 bits so that every fixed ceiling fits.
package pwm_pkg;

    typedef enum logic [1:0] {
        TOP_FIX8  = 2'd0,
        TOP_FIX9  = 2'd1,
        TOP_FIX10 = 2'd2,
        TOP_REG   = 2'd3
    } top_sel_e;

    localparam int FIX_BITS_A = 8;
    localparam int FIX_BITS_B = 9;
    localparam int FIX_BITS_C = 10;

endpackage

// File: rtl/pwm_shadow_reg.sv
// Module: a holding register with a working copy.
// A write lands in the holding buffer only. The working copy is refreshed from
// the buffer value held before this cycle's write, and only when load is high.
// Assumes load and we may both be high in the same cycle.
module pwm_shadow_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         load,
    output logic [W-1:0] buf_q,
    output logic [W-1:0] act_q
);

    // Holding buffer: captures software writes.
    always_ff @(posedge clk) begin
        if (!rst_n)  buf_q <= '0;
        else if (we) buf_q <= wdata;
    end

    // Working copy: follows the buffer at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)    act_q <= '0;
        else if (load) act_q <= buf_q;
    end

endmodule

// File: rtl/pwm_counter.sv
// Module: single-slope up-counter and sticky overflow flag.
// The counter climbs on each tick and returns to zero on the tick after it
// equals top_val. next_top is the ceiling that will apply after a wrap.
// Assumes top_val and next_top are stable within a cycle.
module pwm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] top_val,
    input  logic [W-1:0] next_top,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic         at_top,
    output logic         ovf_flag
);

    logic [W-1:0] cnt_inc;
    logic         ovf_set;

    // Ceiling detect and increment.
    always_comb begin
        at_top  = (cnt == top_val);
        cnt_inc = cnt + 1'b1;
    end

    // Flag set condition: the count is about to equal the ceiling.
    always_comb begin
        if (!tick)       ovf_set = 1'b0;
        else if (at_top) ovf_set = (next_top == '0);
        else             ovf_set = (cnt_inc == top_val);
    end

    // Counter update on enabled ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (tick)   cnt <= at_top ? '0 : cnt_inc;
    end

    // Sticky flag: a set takes priority over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag <= 1'b0;
        else if (ovf_set) ovf_flag <= 1'b1;
        else if (ovf_clr) ovf_flag <= 1'b0;
    end

endmodule

// File: rtl/pwm_level.sv
// Module: output level for the modulated waveform.
// The level is raised on a tick at the compare match and dropped on a tick at
// the ceiling. The match wins when both occur. Polarity is applied outside.
module pwm_level #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp_val,
    input  logic         at_top,
    output logic         level
);

    // Set/clear register with the compare match taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                         level <= 1'b0;
        else if (tick && (cnt == cmp_val))  level <= 1'b1;
        else if (tick && at_top)            level <= 1'b0;
    end

endmodule

// File: rtl/pwm_single_slope.sv
// Module: top of the single-slope modulator.
// Selects the ceiling, buffers the compare and period values until each wrap,
// and applies the output polarity. Assumes tick comes from an external divider.
module pwm_single_slope #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [1:0]   top_mode,
    input  logic         pwm_invert,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    input  logic         per_we,
    input  logic [W-1:0] per_wdata,
    input  logic         ovf_clr,
    output logic         pwm_out,
    output logic         ovf_flag
);
    import pwm_pkg::*;

    localparam logic [W-1:0] FIX_A = W'((1 << FIX_BITS_A) - 1);
    localparam logic [W-1:0] FIX_B = W'((1 << FIX_BITS_B) - 1);
    localparam logic [W-1:0] FIX_C = W'((1 << FIX_BITS_C) - 1);

    logic [W-1:0] cnt, cmp_buf, cmp_act, per_buf, per_act;
    logic [W-1:0] top_val, next_top;
    logic         at_top, wrap, level;
    top_sel_e     sel;

    assign sel  = top_sel_e'(top_mode);
    assign wrap = tick && at_top;

    // Ceiling for this period and for the period after a wrap.
    always_comb begin
        unique case (sel)
            TOP_FIX8:  begin top_val = FIX_A;   next_top = FIX_A;   end
            TOP_FIX9:  begin top_val = FIX_B;   next_top = FIX_B;   end
            TOP_FIX10: begin top_val = FIX_C;   next_top = FIX_C;   end
            default:   begin top_val = per_act; next_top = per_buf; end
        endcase
    end

    pwm_shadow_reg #(.W(W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .we(cmp_we), .wdata(cmp_wdata),
        .load(wrap), .buf_q(cmp_buf), .act_q(cmp_act)
    );

    pwm_shadow_reg #(.W(W)) u_per (
        .clk(clk), .rst_n(rst_n), .we(per_we), .wdata(per_wdata),
        .load(wrap), .buf_q(per_buf), .act_q(per_act)
    );

    pwm_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .top_val(top_val),
        .next_top(next_top), .ovf_clr(ovf_clr), .cnt(cnt),
        .at_top(at_top), .ovf_flag(ovf_flag)
    );

    pwm_level #(.W(W)) u_lvl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt),
        .cmp_val(cmp_act), .at_top(at_top), .level(level)
    );

    // Polarity select.
    assign pwm_out = pwm_invert ? ~level : level;

endmodule

// File: rtl/pwm_single_slope_chk.sv
// Checker: temporal properties of the modulator, attached by bind.
module pwm_single_slope_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         ovf_clr,
    input logic         ovf_flag,
    input logic         at_top,
    input logic [W-1:0] cnt,
    input logic [W-1:0] cmp_act,
    input logic [W-1:0] per_act,
    input logic         cmp_we,
    input logic [W-1:0] cmp_buf
);

    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_top) |=> (cnt == '0));

    p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !at_top) |=> (cnt == $past(cnt) + 1'b1));

    p_cmp_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && at_top) |=> $stable(cmp_act));

    p_per_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(tick && at_top) |=> $stable(per_act));

    p_buf_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_we |=> $stable(cmp_buf));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !tick) |=> !ovf_flag);

endmodule

bind pwm_single_slope pwm_single_slope_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ovf_clr(ovf_clr),
    .ovf_flag(ovf_flag), .at_top(at_top), .cnt(cnt), .cmp_act(cmp_act),
    .per_act(per_act), .cmp_we(cmp_we), .cmp_buf(cmp_buf)
);

// File: tb/sim_pwm_single_slope.sv
`timescale 1ns/1ps
// Bench: scoreboard. The driver task steps a reference model and queues the
// expected outputs; the monitor compares them one cycle later.
module sim_pwm_single_slope;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic [1:0]   top_mode = 2'd0;
    logic         pwm_invert = 1'b0;
    logic         cmp_we = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic         per_we = 1'b0;
    logic [W-1:0] per_wdata = '0;
    logic         ovf_clr = 1'b0;
    logic         pwm_out, ovf_flag;

    always #2 clk = ~clk;

    pwm_single_slope #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .top_mode(top_mode),
        .pwm_invert(pwm_invert), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .per_we(per_we), .per_wdata(per_wdata), .ovf_clr(ovf_clr),
        .pwm_out(pwm_out), .ovf_flag(ovf_flag)
    );

    typedef struct {
        logic  pwm;
        logic  ovf;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    // Reference model state.
    logic [W-1:0] m_cnt, m_bcmp, m_acmp, m_bper, m_aper;
    logic         m_lvl, m_ovf;
    logic [1:0]   s_mode = 2'd0;
    logic         s_inv = 1'b0;

    task automatic check(input logic act, input logic expv, input string what);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", what, act, expv, $time);
        end
    endtask

    function automatic logic [W-1:0] fix_top(input logic [1:0] m, input logic [W-1:0] reg_v);
        case (m)
            2'd0:    return 16'h00FF;
            2'd1:    return 16'h01FF;
            2'd2:    return 16'h03FF;
            default: return reg_v;
        endcase
    endfunction

    // Driver: one cycle of stimulus plus model update and expected push.
    task automatic step(input logic t, input logic wc, input logic [W-1:0] dc,
                        input logic wp, input logic [W-1:0] dp,
                        input logic clr, input string tag);
        logic [W-1:0] topv, nxt;
        logic at, oset;
        exp_t e;
        @(negedge clk);
        tick = t; top_mode = s_mode; pwm_invert = s_inv;
        cmp_we = wc; cmp_wdata = dc; per_we = wp; per_wdata = dp; ovf_clr = clr;
        topv = fix_top(s_mode, m_aper);
        nxt  = fix_top(s_mode, m_bper);
        at   = (m_cnt == topv);
        oset = 1'b0;
        if (t) begin
            if (m_cnt == m_acmp) m_lvl = 1'b1;
            else if (at)         m_lvl = 1'b0;
            oset = at ? (nxt == '0) : (W'(m_cnt + 1) == topv);
            if (at) begin
                m_cnt = '0; m_acmp = m_bcmp; m_aper = m_bper;
            end else begin
                m_cnt = m_cnt + 1'b1;
            end
        end
        if (oset)     m_ovf = 1'b1;
        else if (clr) m_ovf = 1'b0;
        if (wc) m_bcmp = dc;
        if (wp) m_bper = dp;
        e.pwm = m_lvl ^ s_inv; e.ovf = m_ovf; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic run(input int n, input logic t, input string tag);
        for (int i = 0; i < n; i++) step(t, 1'b0, '0, 1'b0, '0, 1'b0, tag);
    endtask

    // Monitor: compares outputs just after each edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(pwm_out, e.pwm, {e.tag, " pwm_out"});
            check(ovf_flag, e.ovf, {e.tag, " ovf_flag"});
        end
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_cnt = '0; m_bcmp = '0; m_acmp = '0; m_bper = '0; m_aper = '0;
        m_lvl = 1'b0; m_ovf = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        check(pwm_out, 1'b0, "R1 reset pwm_out");
        check(ovf_flag, 1'b0, "R1 reset ovf_flag");

        // R1/R8: reg mode with zeroed period, every tick sets the flag.
        s_mode = 2'd3;
        run(3, 1'b1, "R1_R8 zero period");
        // R9: a clear loses to a simultaneous set.
        step(1'b1, 1'b0, '0, 1'b0, '0, 1'b1, "R9 clear vs set");
        // R9: clear with no tick.
        step(1'b0, 1'b0, '0, 1'b0, '0, 1'b1, "R9 clear");
        run(2, 1'b0, "R2 idle");

        // R3/R4: 8-bit ceiling, compare 0x80.
        s_mode = 2'd0;
        step(1'b1, 1'b1, 16'h0080, 1'b0, '0, 1'b0, "R6 cmp write");
        run(700, 1'b1, "R3_R4 fix8");
        // R2: gaps in tick.
        for (int i = 0; i < 300; i++) step(i[0], 1'b0, '0, 1'b0, '0, 1'b0, "R2 gapped");
        step(1'b0, 1'b0, '0, 1'b0, '0, 1'b1, "R8 clear");
        // R5: inverted polarity.
        s_inv = 1'b1;
        run(600, 1'b1, "R5 invert");
        s_inv = 1'b0;
        // 9- and 10-bit ceilings.
        s_mode = 2'd1;
        run(1200, 1'b1, "R3 fix9");
        s_mode = 2'd2;
        run(2400, 1'b1, "R3 fix10");

        // R7: period register mode; period 9, compare 3.
        s_mode = 2'd3;
        step(1'b0, 1'b1, 16'd3, 1'b1, 16'd9, 1'b1, "R7 write");
        run(1200, 1'b1, "R7 settle");
        run(30, 1'b1, "R7 period 9");
        // R6/R7: writes in the wrap cycle apply one period later.
        while (m_cnt != fix_top(2'd3, m_aper)) step(1'b1, 1'b0, '0, 1'b0, '0, 1'b0, "R7 seek");
        step(1'b1, 1'b1, 16'd6, 1'b1, 16'd6, 1'b0, "R6_R7 write at wrap");
        run(25, 1'b1, "R6_R7 after wrap");
        // R4: compare equal to ceiling, match wins.
        step(1'b1, 1'b1, 16'd6, 1'b0, '0, 1'b0, "R4 cmp eq top");
        run(25, 1'b1, "R4 cmp eq top");
        // R9: clear on the tick that reaches the ceiling.
        while (W'(m_cnt + 1) != fix_top(2'd3, m_aper)) step(1'b1, 1'b0, '0, 1'b0, '0, 1'b0, "R9 seek");
        step(1'b1, 1'b0, '0, 1'b0, '0, 1'b1, "R9 clear at top");
        run(10, 1'b1, "R8 sticky");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule